// File: doc/BRIEF.md
# Paged Accumulator Processor

This block is a small 8-bit processor built around one accumulator and four status flags: negative, zero, carry and overflow. Its 12-bit address is a 4-bit page above an 8-bit offset. Instructions are one or two bytes long and are fetched over a plain synchronous memory bus. The bus has a read strobe, a write strobe, a 12-bit address, and separate 8-bit data paths in each direction.

A two-byte memory-reference instruction names a page in its first byte and an offset in its second byte. The operation is load, AND, store or jump. With the indirect bit set, the byte at that location becomes the new offset within the same page. Conditional branches test one flag and move only within the current page. The single-byte group provides a left shift of the accumulator and a no-operation.

A halt output tells the surrounding system that the program has reached a jump to its own address. The processor keeps running after that point.

Top module: `pcpu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the accumulator and all four flags, and holds `halt` low. The first bus cycle after reset is a read of address 0x000.
- R2: A first byte holds the operation in bits 7:5, an indirect bit in bit 4 and the page in bits 3:0. The next byte is the offset. Operations are 000 load, 001 AND, 100 jump and 101 store. With bit 4 clear, the operand address is {page, offset}.
- R3: Every cycle out of reset carries exactly one strobe, `mem_rd` or `mem_wr`, with the address for that cycle. Read data is taken at the end of the cycle. The second byte of an instruction is read from the address after the first byte.
- R4: With bit 4 set, the byte read at {page, offset} replaces the offset, and the page stays the same. The operand, or the jump target, is then {page, that byte}.
- R5: First bytes 0xF0, 0xF2, 0xF4 and 0xF8 branch when N, Z, C or V is set. A taken branch replaces only the low 8 bits of the program counter with the second byte, so the page of the second byte is kept.
- R6: A branch whose flag is clear continues at the address just after its second byte.
- R7: Store writes the accumulator to the operand address in one cycle with `mem_wr` high. It changes no flag.
- R8: Jump loads the whole 12-bit target, page and offset, into the program counter.
- R9: First byte 0xE8 shifts the accumulator left by one bit and fills bit 0 with 0. C takes the old bit 7, V takes old bit 7 XOR old bit 6, and N and Z follow the result. For example, 0x80 gives 0x00 with C, V and Z set.
- R10: First byte 0xE0, and every other 0xE_ value except 0xE8, is a one-byte no-operation.
- R11: Load and AND update N and Z from the new accumulator value and keep C and V. A carry or overflow left by a shift therefore still makes a later C or V branch taken.
- R12: Operations 010, 011 and 110, and 0xF_ first bytes other than the four branches, use two bytes and do nothing else.
- R13: `halt` rises in the cycle after a jump, direct or indirect, resolves to the address of the jump's own first byte. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read strobe for the current cycle |
| mem_wr | output | 1 | Write strobe for the current cycle |
| mem_addr | output | 12 | Bus address, {page, offset} |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rdata | input | 8 | Read data, sampled at the end of a read cycle |
| halt | output | 1 | Set by a jump to its own address |

## Verification
The riskiest overlap is in the cycle where a byte arrives on the bus. In that same cycle the byte must be taken as a pointer, loaded as the new program counter and compared with the jump's own address for `halt`. The test program ends with an indirect jump to itself, so all three happen on one pointer read. A bus-level reference model checks the address of the following fetch and the cycle in which `halt` rises. Flag preservation across loads is provoked by a shift that leaves C and V set, followed by a load and by C and V branches whose targets are checked on the bus.

// File: rtl/pcpu_pkg.sv
package pcpu_pkg;

   typedef enum logic [1:0] {
      ST_FETCH1,
      ST_FETCH2,
      ST_POINTER,
      ST_OPERAND
   } cpu_state_e;

   typedef enum logic [1:0] {
      CL_SHORT,
      CL_MEMREF,
      CL_BRANCH,
      CL_SKIP
   } instr_class_e;

   typedef enum logic [1:0] {
      FN_LOAD,
      FN_AND,
      FN_SHL
   } alu_fn_e;

   // bit order matches the one-hot branch select: [0]=n [1]=z [2]=c [3]=v
   typedef struct packed {
      logic v;
      logic c;
      logic z;
      logic n;
   } flags_t;

   localparam int NUM_FLAGS = 4;

   localparam logic [2:0] OPC_LOAD  = 3'b000;
   localparam logic [2:0] OPC_AND   = 3'b001;
   localparam logic [2:0] OPC_JUMP  = 3'b100;
   localparam logic [2:0] OPC_STORE = 3'b101;

   localparam logic [3:0] GRP_SHORT  = 4'hE;
   localparam logic [3:0] GRP_BRANCH = 4'hF;
   localparam logic [3:0] SHORT_SHL  = 4'h8;

endpackage

// File: rtl/pcpu_decode.sv
module pcpu_decode
   import pcpu_pkg::*;
#(
   parameter int PAGE_W = 4
) (
   input  logic [7:0]          byte_i,
   output instr_class_e        klass_o,
   output logic [2:0]          op_o,
   output logic                ind_o,
   output logic [PAGE_W-1:0]   page_o,
   output logic                shl_o,
   output logic [NUM_FLAGS-1:0] br_sel_o
);

   logic [3:0] grp;
   logic [3:0] low;

   assign grp = byte_i[7:4];
   assign low = byte_i[3:0];

   always_comb begin
      op_o   = byte_i[7:5];
      ind_o  = byte_i[4];
      page_o = byte_i[PAGE_W-1:0];
      shl_o  = (grp == GRP_SHORT) && (low == SHORT_SHL);

      unique case (low)
         4'b0000: br_sel_o = 4'b0001;
         4'b0010: br_sel_o = 4'b0010;
         4'b0100: br_sel_o = 4'b0100;
         4'b1000: br_sel_o = 4'b1000;
         default: br_sel_o = 4'b0000;
      endcase

      if (grp == GRP_SHORT) begin
         klass_o = CL_SHORT;
      end else if (grp == GRP_BRANCH) begin
         klass_o = (br_sel_o != '0) ? CL_BRANCH : CL_SKIP;
      end else begin
         unique case (byte_i[7:5])
            OPC_LOAD, OPC_AND, OPC_JUMP, OPC_STORE: klass_o = CL_MEMREF;
            default:                                klass_o = CL_SKIP;
         endcase
      end
   end

endmodule

// File: rtl/pcpu_cond.sv
module pcpu_cond
   import pcpu_pkg::*;
(
   input  flags_t               flg_i,
   input  logic [NUM_FLAGS-1:0] sel_i,
   output logic                 taken_o
);

   logic [NUM_FLAGS-1:0] flg_vec;
   logic [NUM_FLAGS-1:0] hit;

   assign flg_vec = flg_i;

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_hit
      assign hit[gi] = sel_i[gi] & flg_vec[gi];
   end

   assign taken_o = |hit;

endmodule

// File: rtl/pcpu_alu.sv
module pcpu_alu
   import pcpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_fn_e             fn_i,
   input  logic [DATA_W-1:0]   acc_i,
   input  logic [DATA_W-1:0]   opnd_i,
   input  logic                c_i,
   input  logic                v_i,
   output logic [DATA_W-1:0]   res_o,
   output flags_t              flg_o
);

   localparam int MSB = DATA_W - 1;

   always_comb begin
      flg_o.c = c_i;
      flg_o.v = v_i;
      unique case (fn_i)
         FN_AND:  res_o = acc_i & opnd_i;
         FN_SHL: begin
            res_o   = {acc_i[MSB-1:0], 1'b0};
            flg_o.c = acc_i[MSB];
            flg_o.v = acc_i[MSB] ^ acc_i[MSB-1];
         end
         default: res_o = opnd_i;
      endcase
      flg_o.n = res_o[MSB];
      flg_o.z = (res_o == '0);
   end

endmodule

// File: rtl/pcpu_core.sv
module pcpu_core
   import pcpu_pkg::*;
#(
   parameter  int DATA_W  = 8,
   parameter  int PAGE_W  = 4,
   parameter  bit HALT_EN = 1'b1,
   localparam int AW      = PAGE_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [AW-1:0]     mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halt
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("pcpu_core: instruction encoding needs DATA_W == 8");
   end
   if (PAGE_W < 1 || PAGE_W > 4) begin : g_bad_page_w
      $error("pcpu_core: page field must be 1 to 4 bits");
   end

   cpu_state_e          state_q;
   logic [AW-1:0]       pc_q;
   logic [AW-1:0]       ia_q;
   logic [DATA_W-1:0]   ir_q;
   logic [DATA_W-1:0]   off_q;
   logic [DATA_W-1:0]   acc_q;
   flags_t              flg_q;
   logic                halt_q;

   logic [DATA_W-1:0]   dec_byte;
   instr_class_e        klass;
   logic [2:0]          op;
   logic                ind;
   logic [PAGE_W-1:0]   page;
   logic                shl;
   logic [NUM_FLAGS-1:0] br_sel;
   logic                taken;

   alu_fn_e             alu_fn;
   logic [DATA_W-1:0]   alu_res;
   flags_t              alu_flg;
   logic                acc_we;

   logic [AW-1:0]       oper_addr;
   logic [AW-1:0]       pc_inc;
   logic [AW-1:0]       jmp_tgt;
   logic [AW-1:0]       br_tgt;
   logic                jmp_fire;

   // first byte is decoded straight off the bus while it is fetched
   assign dec_byte = (state_q == ST_FETCH1) ? mem_rdata : ir_q;

   pcpu_decode #(.PAGE_W(PAGE_W)) u_decode (
      .byte_i   (dec_byte),
      .klass_o  (klass),
      .op_o     (op),
      .ind_o    (ind),
      .page_o   (page),
      .shl_o    (shl),
      .br_sel_o (br_sel)
   );

   pcpu_cond u_cond (
      .flg_i   (flg_q),
      .sel_i   (br_sel),
      .taken_o (taken)
   );

   always_comb begin
      if (state_q == ST_FETCH1)  alu_fn = FN_SHL;
      else if (op == OPC_AND)    alu_fn = FN_AND;
      else                       alu_fn = FN_LOAD;
   end

   pcpu_alu #(.DATA_W(DATA_W)) u_alu (
      .fn_i   (alu_fn),
      .acc_i  (acc_q),
      .opnd_i (mem_rdata),
      .c_i    (flg_q.c),
      .v_i    (flg_q.v),
      .res_o  (alu_res),
      .flg_o  (alu_flg)
   );

   assign oper_addr = {page, off_q};
   assign pc_inc    = pc_q + 1'b1;
   assign jmp_tgt   = {page, mem_rdata};
   assign br_tgt    = {pc_q[AW-1:DATA_W], mem_rdata};

   assign acc_we = ((state_q == ST_FETCH1) && (klass == CL_SHORT) && shl) ||
                   ((state_q == ST_OPERAND) && (op != OPC_STORE));

   assign jmp_fire = (op == OPC_JUMP) &&
                     (((state_q == ST_FETCH2) && (klass == CL_MEMREF) && !ind) ||
                      (state_q == ST_POINTER));

   // bus drive: exactly one strobe per cycle
   always_comb begin
      mem_rd   = 1'b0;
      mem_wr   = 1'b0;
      mem_addr = pc_q;
      unique case (state_q)
         ST_FETCH1, ST_FETCH2: mem_rd = 1'b1;
         ST_POINTER: begin
            mem_rd   = 1'b1;
            mem_addr = oper_addr;
         end
         default: begin
            mem_addr = oper_addr;
            if (op == OPC_STORE) mem_wr = 1'b1;
            else                 mem_rd = 1'b1;
         end
      endcase
   end

   assign mem_wdata = acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_FETCH1;
         pc_q    <= '0;
         ia_q    <= '0;
         ir_q    <= '0;
         off_q   <= '0;
         acc_q   <= '0;
         flg_q   <= '0;
      end else begin
         if (acc_we) begin
            acc_q <= alu_res;
            flg_q <= alu_flg;
         end
         unique case (state_q)
            ST_FETCH1: begin
               ir_q    <= mem_rdata;
               ia_q    <= pc_q;
               pc_q    <= pc_inc;
               state_q <= (klass == CL_SHORT) ? ST_FETCH1 : ST_FETCH2;
            end
            ST_FETCH2: begin
               off_q   <= mem_rdata;
               state_q <= ST_FETCH1;
               if (jmp_fire)                            pc_q <= jmp_tgt;
               else if ((klass == CL_BRANCH) && taken)  pc_q <= br_tgt;
               else                                     pc_q <= pc_inc;
               if (klass == CL_MEMREF) begin
                  if (ind)                  state_q <= ST_POINTER;
                  else if (op != OPC_JUMP)  state_q <= ST_OPERAND;
               end
            end
            ST_POINTER: begin
               off_q <= mem_rdata;
               if (jmp_fire) begin
                  pc_q    <= jmp_tgt;
                  state_q <= ST_FETCH1;
               end else begin
                  state_q <= ST_OPERAND;
               end
            end
            default: state_q <= ST_FETCH1;
         endcase
      end
   end

   if (HALT_EN) begin : g_halt
      always_ff @(posedge clk) begin
         if (rst)                                halt_q <= 1'b0;
         else if (jmp_fire && (jmp_tgt == ia_q)) halt_q <= 1'b1;
      end
   end else begin : g_no_halt
      assign halt_q = 1'b0;
   end

   assign halt = halt_q;

endmodule

// File: rtl/pcpu_core_chk.sv
module pcpu_core_chk
   import pcpu_pkg::*;
#(
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic          halt,
   input cpu_state_e    state_q,
   input flags_t        flg_q
);

   // R1
   first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem_rd && !mem_wr && (mem_addr == '0)));

   // R3
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_rd != mem_wr));

   // R3
   next_byte_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FETCH2) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

   // R7
   store_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_OPERAND && mem_wr) |=> $stable(flg_q));

   // R11
   load_keeps_cv_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_OPERAND && mem_rd) |=> $stable({flg_q.c, flg_q.v}));

   // R13
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halt |=> halt);

endmodule

bind pcpu_core pcpu_core_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .halt     (halt),
   .state_q  (state_q),
   .flg_q    (flg_q)
);

// File: tb/pcpu_core_tb.sv
module pcpu_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 3000;
   localparam int MEM_N      = 2048;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_rd, mem_wr, halt;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [7:0] bmem [0:MEM_N-1];
   logic [7:0] rmem [0:MEM_N-1];

   assign mem_rdata = bmem[mem_addr[10:0]];
   always @(posedge clk) if (mem_wr) bmem[mem_addr[10:0]] <= mem_wdata;

   pcpu_core u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halt      (halt)
   );

   typedef struct packed {
      logic        rd;
      logic        wr;
      logic [11:0] addr;
      logic [7:0]  wdata;
      logic        set_halt;
      logic [31:0] tag;
   } bus_ev_t;

   bus_ev_t     exp_q[$];
   int          checks = 0;
   int          errors = 0;
   logic [11:0] m_pc;
   logic [7:0]  m_acc;
   logic        m_n, m_z, m_c, m_v;
   logic [31:0] next_tag;
   logic        halt_exp;

   task automatic put(input logic [11:0] a, input logic [7:0] d);
      bmem[a[10:0]] = d;
      rmem[a[10:0]] = d;
   endtask

   task automatic push_ev(input logic rd, input logic wr, input logic [11:0] a,
                          input logic [7:0] d, input logic [31:0] tag, input logic sh);
      bus_ev_t e;
      e.rd = rd; e.wr = wr; e.addr = a; e.wdata = d; e.set_halt = sh; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // behavioural instruction-level model producing the expected bus cycles
   task automatic iss_step();
      logic [11:0] ia, p2, ea;
      logic [7:0]  b1, b2, opnd;
      logic [2:0]  op;
      logic        tk;
      ia = m_pc;
      b1 = rmem[ia[10:0]];
      push_ev(1'b1, 1'b0, ia, 8'h00, next_tag, 1'b0);
      m_pc = ia + 12'd1;
      next_tag = "R3";
      if (b1[7:4] == 4'hE) begin
         if (b1[3:0] == 4'h8) begin
            m_c   = m_acc[7];
            m_v   = m_acc[7] ^ m_acc[6];
            m_acc = {m_acc[6:0], 1'b0};
            m_n   = m_acc[7];
            m_z   = (m_acc == 8'h00);
            next_tag = "R9";
         end else begin
            next_tag = "R10";
         end
         return;
      end
      p2 = m_pc;
      b2 = rmem[p2[10:0]];
      m_pc = p2 + 12'd1;
      op = b1[7:5];
      ea = {b1[3:0], b2};
      if (b1[7:4] == 4'hF) begin
         push_ev(1'b1, 1'b0, p2, 8'h00, "R3", 1'b0);
         case (b1[3:0])
            4'h0: tk = m_n;
            4'h2: tk = m_z;
            4'h4: tk = m_c;
            4'h8: tk = m_v;
            default: begin
               next_tag = "R12";
               return;
            end
         endcase
         if (tk) begin
            m_pc = {p2[11:8], b2};
            next_tag = (b1[3:0] >= 4'h4) ? "R11" : "R5";
         end else begin
            next_tag = "R6";
         end
         return;
      end
      if (!(op == 3'b000 || op == 3'b001 || op == 3'b100 || op == 3'b101)) begin
         push_ev(1'b1, 1'b0, p2, 8'h00, "R3", 1'b0);
         next_tag = "R12";
         return;
      end
      push_ev(1'b1, 1'b0, p2, 8'h00, "R3", (op == 3'b100) && !b1[4] && (ea == ia));
      if (b1[4]) begin
         opnd = rmem[ea[10:0]];
         push_ev(1'b1, 1'b0, ea, 8'h00, "R4", (op == 3'b100) && ({b1[3:0], opnd} == ia));
         ea = {b1[3:0], opnd};
      end
      case (op)
         3'b100: begin
            m_pc = ea;
            next_tag = "R8";
         end
         3'b101: begin
            push_ev(1'b0, 1'b1, ea, m_acc, "R7", 1'b0);
            rmem[ea[10:0]] = m_acc;
         end
         default: begin
            push_ev(1'b1, 1'b0, ea, 8'h00, "R2", 1'b0);
            if (op == 3'b000) m_acc = rmem[ea[10:0]];
            else              m_acc = m_acc & rmem[ea[10:0]];
            m_n = m_acc[7];
            m_z = (m_acc == 8'h00);
         end
      endcase
   endtask

   task automatic compare_cycle();
      bus_ev_t     e;
      logic        ok_bus, ok_halt;
      logic [31:0] tg;
      if (exp_q.size() == 0) iss_step();
      e = exp_q.pop_front();
      ok_bus = (mem_rd === e.rd) && (mem_wr === e.wr) && (mem_addr === e.addr) &&
               (!e.wr || (mem_wdata === e.wdata));
      ok_halt = (halt === halt_exp);
      tg = ok_halt ? e.tag : "R13";
      checks++;
      if (!ok_bus || !ok_halt) begin
         errors++;
         $display("FAIL %s: got rd=%0b wr=%0b addr=%03h wdata=%02h halt=%0b, expected rd=%0b wr=%0b addr=%03h wdata=%02h halt=%0b",
                  tg, mem_rd, mem_wr, mem_addr, mem_wdata, halt,
                  e.rd, e.wr, e.addr, e.wdata, halt_exp);
      end
      if (e.set_halt) halt_exp = 1'b1;
   endtask

   task automatic check_val(input logic [31:0] tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
      end
   endtask

   initial begin
      int after_halt;
      bit done;
      for (int i = 0; i < MEM_N; i++) put(12'(i), 8'h00);
      // program, page 0
      put(12'h000, 8'hA0); put(12'h001, 8'h7A);   // store reset accumulator
      put(12'h002, 8'hF4); put(12'h003, 8'h40);   // C clear after reset
      put(12'h004, 8'h05); put(12'h005, 8'h0C);   // load 0xFF
      put(12'h006, 8'h20); put(12'h007, 8'h71);   // AND 0x00
      put(12'h008, 8'hA0); put(12'h009, 8'h73);
      put(12'h00A, 8'hF0); put(12'h00B, 8'h78);   // N clear
      put(12'h00C, 8'hF2); put(12'h00D, 8'h10);   // Z set
      put(12'h00E, 8'h80); put(12'h00F, 8'h78);
      put(12'h010, 8'h00); put(12'h011, 8'h60);   // load 0xA5
      put(12'h012, 8'h35); put(12'h013, 8'h00);   // AND through pointer
      put(12'h014, 8'hA0); put(12'h015, 8'h75);
      put(12'h016, 8'hF0); put(12'h017, 8'h1A);   // N set
      put(12'h018, 8'h80); put(12'h019, 8'h78);
      put(12'h01A, 8'hE3);                        // unused short code
      put(12'h01B, 8'hC7); put(12'h01C, 8'h55);   // operation 110
      put(12'h01D, 8'hF3); put(12'h01E, 8'h78);   // unused branch code
      put(12'h01F, 8'h05); put(12'h020, 8'h0E);   // load 0x80
      put(12'h021, 8'hE8);                        // shift: 0x00, C, V
      put(12'h022, 8'hE0);
      put(12'h023, 8'h00); put(12'h024, 8'h61);   // load 0x5A
      put(12'h025, 8'hA0); put(12'h026, 8'h76);
      put(12'h027, 8'hF4); put(12'h028, 8'h2B);
      put(12'h029, 8'h80); put(12'h02A, 8'h78);
      put(12'h02B, 8'hF8); put(12'h02C, 8'h2F);
      put(12'h02D, 8'h80); put(12'h02E, 8'h78);
      put(12'h02F, 8'hE8);                        // shift 0x5A -> 0xB4
      put(12'h030, 8'hA0); put(12'h031, 8'h77);
      put(12'h032, 8'hF4); put(12'h033, 8'h78);   // C clear now
      put(12'h034, 8'h85); put(12'h035, 8'h10);   // jump to page 5
      put(12'h060, 8'hA5); put(12'h061, 8'h5A);
      put(12'h078, 8'h80); put(12'h079, 8'h78);
      put(12'h073, 8'h33); put(12'h075, 8'h33); put(12'h076, 8'h33);
      put(12'h077, 8'h33); put(12'h07A, 8'h33);
      // page 5
      put(12'h500, 8'h08); put(12'h506, 8'h14);
      put(12'h508, 8'hA5); put(12'h50C, 8'hFF); put(12'h50E, 8'h80);
      put(12'h510, 8'h05); put(12'h511, 8'h0C);
      put(12'h512, 8'hA5); put(12'h513, 8'h17);
      put(12'h514, 8'h95); put(12'h515, 8'h06);   // indirect jump to itself
      put(12'h517, 8'h33);

      m_pc = 12'h000; m_acc = 8'h00;
      m_n = 1'b0; m_z = 1'b0; m_c = 1'b0; m_v = 1'b0;
      next_tag = "R1"; halt_exp = 1'b0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state on the bus
      check_val("R1", {11'd0, mem_rd}, 12'h001);
      check_val("R1", mem_addr, 12'h000);
      check_val("R1", {11'd0, halt}, 12'h000);
      rst = 1'b0;

      after_halt = 0;
      done = 1'b0;
      for (int cyc = 0; cyc < LIMIT && !done; cyc++) begin
         compare_cycle();
         if (halt_exp) after_halt++;
         if (after_halt > 8) done = 1'b1;
         @(negedge clk);
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R13: watchdog, halt=%0b expected 1 within %0d cycles", halt, LIMIT);
      end

      check_val("R1",  {4'd0, bmem[12'h07A]}, 12'h000);
      check_val("R2",  {4'd0, bmem[12'h073]}, 12'h000);
      check_val("R4",  {4'd0, bmem[12'h075]}, 12'h0A5);
      check_val("R11", {4'd0, bmem[12'h076]}, 12'h05A);
      check_val("R9",  {4'd0, bmem[12'h077]}, 12'h0B4);
      check_val("R8",  {4'd0, bmem[12'h517]}, 12'h0FF);
      check_val("R13", {11'd0, halt}, 12'h001);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule